// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Channel

This block is the receive half of a frame DMA engine. It takes a byte stream coming off a serial line and stores each frame in buffers in a shared memory. A ring of descriptors in that same memory names the buffers. Every descriptor is four-byte aligned and holds three words:
- offset 0: a 32-bit link to the next descriptor;
- offset 4: a 32-bit buffer address;
- offset 8: a writeback word, with the byte count in bits [15:0] and a status byte in bits [23:16].

The engine starts at the descriptor named by its current-pointer register and fills that buffer. When the frame ends, or the buffer fills, it writes the count and status back and then follows the link.

Software owns the stop pointer. The engine never fills the descriptor the stop pointer names. A frame that arrives while the current pointer sits on it is thrown away and flagged as an overflow. Software moves the stop pointer forward as it frees descriptors.

Completed frames are counted. A level interrupt stays high while that count is non-zero. Software clears the count with a command.

Top module: `rxchain_dma`

## Requirements
- R1: After reset, CUR (register 0) and STOP (register 1) read 0, CSR (register 4) reads 0, irq_eom is 0 and in_ready is 0.
- R2: A frame starts when in_valid is high while DE (CSR bit 1) is set and CUR differs from STOP. The engine reads the link at CUR and the buffer address at CUR+4. Byte k of the descriptor's data is then written to buffer+k, with the byte copied to every lane and a one-hot strobe `1 << address[1:0]`.
- R3: At frame end the word at CUR+8 is written with all strobes set. It holds:
  - bits [15:0]: the byte count for this descriptor;
  - bits [23:16]: the status byte;
  - bits [31:24]: zero.

  The status byte has end-of-message in bit 7, and overrun, short frame, abort, residual bits and CRC error in bits 6 to 2, taken from in_err[4:0] on the last byte. Bits 1 and 0 are zero.
- R4: CUR takes the link value only after the writeback of that descriptor has been issued.
- R5: When BLEN (register 2) bytes have filled a buffer before the frame's last byte, the writeback has count BLEN and status 0. The frame then continues into the next descriptor.
- R6: A frame arriving while CUR equals STOP is accepted and discarded without any memory write, and CUR stays unchanged. The BOF flag (CSR bit 5) is set.
- R7: The EOT flag (CSR bit 7) is set when CUR advances onto STOP.
- R8: Each completed frame sets the EOM flag (CSR bit 6) and increments the frame count. irq_eom is high while the count is non-zero. A CMD (register 5) write with bit 1 set clears the count.
- R9: The frame count saturates at 2^CNT_W-1. A frame completing at saturation sets COF (CSR bit 4).
- R10: A CSR write with bit 0 set clears each flag whose bit is 1 and leaves DE unchanged. A CSR write with bit 0 clear loads DE from bit 1 and leaves the flags unchanged.
- R11: With DE clear, no new descriptor is started: in_ready stays 0 and the memory port stays idle.
- R12: A CMD write with bit 0 set clears DE, all four flags and the frame count.
- R13: MODE (register 3) 0x14 keeps the channel running across frames. Any other MODE value clears DE when a frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Byte lane strobes for writes |
| mem_rdata | input | 32 | Read data, one cycle after the read request |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err | input | 5 | Frame error flags, meaningful with in_last |
| in_ready | output | 1 | Stream byte accepted this cycle |
| irq_eom | output | 1 | Frame-count interrupt |

## Verification
The checks assume the memory accepts every request in its own cycle and returns read data exactly one cycle later. The bench's memory model behaves that way.

They also assume software does not write CUR or STOP while a descriptor is in flight. Otherwise the writeback-before-advance check and the EOT check would see a pointer the engine did not move. The bench changes pointers only while the engine is idle.

The bench holds in_err at zero except on a frame's last byte.

BLEN must be non-zero; the bench programs 16.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // descriptor field offsets (bytes) and writeback field width
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned OFS_LINK   = 0;
  localparam int unsigned OFS_BUF    = 4;
  localparam int unsigned OFS_WB     = 8;

  // register selects
  localparam logic [2:0] RG_CUR  = 3'd0;
  localparam logic [2:0] RG_STOP = 3'd1;
  localparam logic [2:0] RG_BLEN = 3'd2;
  localparam logic [2:0] RG_MODE = 3'd3;
  localparam logic [2:0] RG_CSR  = 3'd4;
  localparam logic [2:0] RG_CMD  = 3'd5;

  // CSR bit positions
  localparam int unsigned CB_DWE = 0;
  localparam int unsigned CB_DE  = 1;
  localparam int unsigned CB_COF = 4;
  localparam int unsigned CB_BOF = 5;
  localparam int unsigned CB_EOM = 6;
  localparam int unsigned CB_EOT = 7;

  // command bits
  localparam int unsigned KB_ABORT = 0;
  localparam int unsigned KB_CLRCNT = 1;

  localparam logic [7:0] MODE_CHAIN_MULTI = 8'h14;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_LINK, S_RD_BUF, S_GET_BUF, S_XFER, S_WB, S_ADV, S_DROP
  } walk_state_e;

endpackage

// File: rtl/rxd_csr.sv
module rxd_csr
  import rxd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stop,
  input  logic              wr_blen,
  input  logic              wr_mode,
  input  logic              wr_csr,
  input  logic              wr_cmd,
  input  logic [31:0]       wdata,
  input  logic              ev_frame,
  input  logic              ev_eot,
  input  logic              ev_drop,
  output logic [ADDR_W-1:0] stop_addr,
  output logic [LEN_W-1:0]  blen,
  output logic [7:0]        mode,
  output logic              de,
  output logic [7:0]        csr_rd,
  output logic [CNT_W-1:0]  cnt,
  output logic              irq_eom
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ADDR_W-1:0] stop_q, stop_d;
  logic [LEN_W-1:0]  blen_q, blen_d;
  logic [7:0]        mode_q, mode_d;
  logic              de_q, de_d;
  logic [3:0]        flg_q, flg_d;   // {eot, eom, bof, cof}
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[31:8], wdata[3:2]};

  always_comb begin
    stop_d = stop_q;
    blen_d = blen_q;
    mode_d = mode_q;
    de_d   = de_q;
    flg_d  = flg_q;
    cnt_d  = cnt_q;

    if (wr_stop) stop_d = wdata[ADDR_W-1:0];
    if (wr_blen) blen_d = wdata[LEN_W-1:0];
    if (wr_mode) mode_d = wdata[7:0];
    if (wr_csr) begin
      if (wdata[CB_DWE]) flg_d = flg_q & ~wdata[7:4];
      else               de_d  = wdata[CB_DE];
    end

    // hardware events win over a software clear in the same cycle
    if (ev_eot)  flg_d[3] = 1'b1;
    if (ev_drop) flg_d[1] = 1'b1;
    if (ev_frame) begin
      flg_d[2] = 1'b1;
      if (cnt_q == CNT_MAX) flg_d[0] = 1'b1;
      else                  cnt_d = cnt_q + 1'b1;
      if (mode_q != MODE_CHAIN_MULTI) de_d = 1'b0;
    end

    if (wr_cmd && wdata[KB_CLRCNT]) cnt_d = '0;
    if (wr_cmd && wdata[KB_ABORT]) begin
      de_d  = 1'b0;
      flg_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= '0;
      blen_q <= '0;
      mode_q <= '0;
      de_q   <= 1'b0;
      flg_q  <= '0;
      cnt_q  <= '0;
    end else begin
      stop_q <= stop_d;
      blen_q <= blen_d;
      mode_q <= mode_d;
      de_q   <= de_d;
      flg_q  <= flg_d;
      cnt_q  <= cnt_d;
    end
  end

  assign stop_addr = stop_q;
  assign blen      = blen_q;
  assign mode      = mode_q;
  assign de        = de_q;
  assign cnt       = cnt_q;
  assign irq_eom   = (cnt_q != '0);
  assign csr_rd    = {flg_q, 2'b00, de_q, 1'b0};

endmodule

// File: rtl/rxd_walker.sv
module rxd_walker
  import rxd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de,
  input  logic [ADDR_W-1:0] stop_addr,
  input  logic [LEN_W-1:0]  blen,
  input  logic              cur_wr,
  input  logic [ADDR_W-1:0] cur_wdata,
  input  logic              abort,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [4:0]        in_err,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-1:0] cur,
  output logic              busy,
  output logic              ev_frame,
  output logic              ev_eot,
  output logic              ev_drop
);

  walk_state_e       st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] link_q, link_d;
  logic [ADDR_W-1:0] buf_q, buf_d;
  logic [LEN_W-1:0]  offs_q, offs_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [7:0]        stat_q, stat_d;
  logic [ADDR_W-1:0] offs_ext;
  logic [ADDR_W-1:0] byte_addr;
  logic [LEN_W-1:0]  offs_inc;
  logic [31:0]       rd_unused_pad;

  always_comb begin
    offs_ext = '0;
    offs_ext[LEN_W-1:0] = offs_q;
  end

  assign byte_addr     = buf_q + offs_ext;
  assign offs_inc      = offs_q + 1'b1;
  assign rd_unused_pad = mem_rdata;

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    link_d    = link_q;
    buf_d     = buf_q;
    offs_d    = offs_q;
    len_d     = len_q;
    stat_d    = stat_q;
    in_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    mem_wstrb = '0;
    ev_frame  = 1'b0;
    ev_eot    = 1'b0;
    ev_drop   = 1'b0;

    unique case (st_q)
      S_IDLE: begin
        if (de && in_valid) begin
          if (cur_q == stop_addr) begin
            st_d    = S_DROP;
            ev_drop = 1'b1;
          end else begin
            st_d = S_RD_LINK;
          end
        end
      end
      S_RD_LINK: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + ADDR_W'(OFS_LINK);
        st_d     = S_RD_BUF;
      end
      S_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + ADDR_W'(OFS_BUF);
        link_d   = rd_unused_pad[ADDR_W-1:0];
        st_d     = S_GET_BUF;
      end
      S_GET_BUF: begin
        buf_d  = rd_unused_pad[ADDR_W-1:0];
        offs_d = '0;
        st_d   = S_XFER;
      end
      S_XFER: begin
        in_ready = 1'b1;
        if (in_valid) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = byte_addr;
          mem_wdata = {4{in_data}};
          mem_wstrb = 4'b0001 << byte_addr[1:0];
          offs_d    = offs_inc;
          if (in_last || (offs_inc == blen)) begin
            len_d  = offs_inc;
            stat_d = {in_last, (in_last ? in_err : 5'b0), 2'b00};
            st_d   = S_WB;
          end
        end
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + ADDR_W'(OFS_WB);
        mem_wdata = {8'h00, stat_q, len_q};
        mem_wstrb = 4'hF;
        st_d      = S_ADV;
      end
      S_ADV: begin
        cur_d    = link_q;
        ev_frame = stat_q[7];
        ev_eot   = (link_q == stop_addr);
        st_d     = S_IDLE;
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase

    if (cur_wr && (st_q != S_ADV)) cur_d = cur_wdata;
    if (abort) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      link_q <= '0;
      buf_q  <= '0;
      offs_q <= '0;
      len_q  <= '0;
      stat_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      link_q <= link_d;
      buf_q  <= buf_d;
      offs_q <= offs_d;
      len_q  <= len_d;
      stat_q <= stat_d;
    end
  end

  assign cur  = cur_q;
  assign busy = (st_q != S_IDLE);

endmodule

// File: rtl/rxchain_dma.sv
module rxchain_dma
  import rxd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic [31:0]       mem_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [4:0]        in_err,
  output logic              in_ready,
  output logic              irq_eom
);

  logic [ADDR_W-1:0] cur, stop_addr;
  logic [LEN_W-1:0]  blen;
  logic [7:0]        mode, csr_rd;
  logic [CNT_W-1:0]  cnt;
  logic              de, busy, ev_frame, ev_eot, ev_drop;
  logic              wr_cur, wr_stop, wr_blen, wr_mode, wr_csr, wr_cmd;
  logic [31:0]       cur32, stop32, blen32;

  assign wr_cur  = reg_wr && (reg_addr == RG_CUR);
  assign wr_stop = reg_wr && (reg_addr == RG_STOP);
  assign wr_blen = reg_wr && (reg_addr == RG_BLEN);
  assign wr_mode = reg_wr && (reg_addr == RG_MODE);
  assign wr_csr  = reg_wr && (reg_addr == RG_CSR);
  assign wr_cmd  = reg_wr && (reg_addr == RG_CMD);

  rxd_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_stop(wr_stop), .wr_blen(wr_blen), .wr_mode(wr_mode),
    .wr_csr(wr_csr), .wr_cmd(wr_cmd), .wdata(reg_wdata),
    .ev_frame(ev_frame), .ev_eot(ev_eot), .ev_drop(ev_drop),
    .stop_addr(stop_addr), .blen(blen), .mode(mode), .de(de),
    .csr_rd(csr_rd), .cnt(cnt), .irq_eom(irq_eom)
  );

  rxd_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .de(de), .stop_addr(stop_addr), .blen(blen),
    .cur_wr(wr_cur), .cur_wdata(reg_wdata[ADDR_W-1:0]),
    .abort(wr_cmd && reg_wdata[KB_ABORT]),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
    .cur(cur), .busy(busy),
    .ev_frame(ev_frame), .ev_eot(ev_eot), .ev_drop(ev_drop)
  );

  always_comb begin
    cur32  = '0; cur32[ADDR_W-1:0]  = cur;
    stop32 = '0; stop32[ADDR_W-1:0] = stop_addr;
    blen32 = '0; blen32[LEN_W-1:0]  = blen;
    unique case (reg_addr)
      RG_CUR:  reg_rdata = cur32;
      RG_STOP: reg_rdata = stop32;
      RG_BLEN: reg_rdata = blen32;
      RG_MODE: reg_rdata = {24'h0, mode};
      RG_CSR:  reg_rdata = {24'h0, csr_rd};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rxd_chk.sv
module rxd_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              de,
  input logic              busy,
  input logic [ADDR_W-1:0] cur,
  input logic [ADDR_W-1:0] stop_addr,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_wstrb,
  input logic [7:0]        csr_rd,
  input logic [CNT_W-1:0]  cnt,
  input logic              irq_eom
);

  logic [ADDR_W-1:0] cur_prev;
  logic              wb_seen, sw_cur_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prev    <= '0;
      wb_seen     <= 1'b0;
      sw_cur_prev <= 1'b0;
    end else begin
      cur_prev    <= cur;
      sw_cur_prev <= reg_wr && (reg_addr == 3'd0);
      if (cur != cur_prev)
        wb_seen <= 1'b0;
      else if (mem_req && mem_we && (mem_wstrb == 4'hF) &&
               (mem_addr == cur + ADDR_W'(8)))
        wb_seen <= 1'b1;
    end
  end

  p_strb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (($countones(mem_wstrb) == 1) || (mem_wstrb == 4'hF)));

  p_wb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur != cur_prev) && !sw_cur_prev) |-> wb_seen);

  p_bof_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rd[5]) |-> $past(cur == stop_addr));

  p_eot_at_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rd[7]) |-> (cur == stop_addr));

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 3'd5) && reg_wdata[1]) |=> !irq_eom);

  p_cof_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rd[4]) |-> $past(cnt == {CNT_W{1'b1}}));

  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!de && !busy) |=> !busy);

endmodule

bind rxchain_dma rxd_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .busy(busy), .cur(cur),
  .stop_addr(stop_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .csr_rd(csr_rd),
  .cnt(cnt), .irq_eom(irq_eom)
);

// File: tb/rxchain_dma_bench.sv
module rxchain_dma_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic        in_valid, in_last, in_ready, irq_eom;
  logic [7:0]  in_data;
  logic [4:0]  in_err;

  logic [31:0] mem [0:255];
  int total, bad;
  logic done;

  rxchain_dma #(.ADDR_W(32), .CNT_W(2)) u_rxchain_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .in_ready(in_ready), .irq_eom(irq_eom)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // shared memory: accepts every request, read data one cycle later
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  function automatic logic [7:0] mbyte(input int a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input int n, input logic [7:0] base, input logic [4:0] err);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = base + 8'(k);
      in_last  = (k == n - 1);
      in_err   = (k == n - 1) ? err : 5'b0;
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 5'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); check("R1 cur", d, 0);
    rd(3'd1, d); check("R1 stop", d, 0);
    rd(3'd4, d); check("R1 csr", d, 0);
    check("R1 irq", {31'b0, irq_eom}, 0);
    check("R1 in_ready", {31'b0, in_ready}, 0);
  endtask

  task automatic t_short_frame;
    logic [31:0] d;
    wr(3'd0, 32'h0); wr(3'd1, 32'h30); wr(3'd2, 32'd16);
    wr(3'd3, 32'h14); wr(3'd4, 32'h02);
    send(5, 8'hA0, 5'b0);
    for (int k = 0; k < 5; k++) check("R2 byte", {24'b0, mbyte(32'h200 + k)}, 32'hA0 + k);
    check("R2 untouched byte", {24'b0, mbyte(32'h205)}, 0);
    check("R3 writeback", mem[2], 32'h0080_0005);
    rd(3'd0, d); check("R4 cur follows link", d, 32'h10);
    rd(3'd4, d); check("R8 eom flag", d, 32'h42);
    check("R8 irq", {31'b0, irq_eom}, 1);
  endtask

  task automatic t_long_frame;
    logic [31:0] d;
    send(20, 8'h10, 5'b00001);
    check("R5 full buffer writeback", mem[6], 32'h0000_0010);
    for (int k = 0; k < 16; k++) check("R5 byte", {24'b0, mbyte(32'h240 + k)}, 32'h10 + k);
    check("R3 crc status", mem[10], 32'h0084_0004);
    for (int k = 0; k < 4; k++) check("R5 tail byte", {24'b0, mbyte(32'h280 + k)}, 32'h20 + k);
    rd(3'd0, d); check("R7 cur at stop", d, 32'h30);
    rd(3'd4, d); check("R7 eot flag", d, 32'hC2);
  endtask

  task automatic t_drop;
    logic [31:0] d;
    send(3, 8'h55, 5'b0);
    rd(3'd4, d); check("R6 bof flag", d, 32'hE2);
    rd(3'd0, d); check("R6 cur kept", d, 32'h30);
    check("R6 no writeback", mem[14], 0);
    check("R6 no data", {24'b0, mbyte(32'h2C0)}, 0);
  endtask

  task automatic t_flag_clear;
    logic [31:0] d;
    wr(3'd4, 32'hF1);
    rd(3'd4, d); check("R10 w1c keeps DE", d, 32'h02);
    check("R10 irq unaffected", {31'b0, irq_eom}, 1);
    wr(3'd5, 32'h2);
    check("R8 count clear", {31'b0, irq_eom}, 0);
  endtask

  task automatic t_advance_stop;
    logic [31:0] d;
    wr(3'd1, 32'h10);
    send(2, 8'h77, 5'b10000);
    check("R3 overrun status", mem[14], 32'h00C0_0002);
    check("R2 byte", {24'b0, mbyte(32'h2C0)}, 32'h77);
    check("R2 byte", {24'b0, mbyte(32'h2C1)}, 32'h78);
    rd(3'd0, d); check("R4 ring wrap", d, 32'h00);
    rd(3'd4, d); check("R7 no eot", d, 32'h42);
    check("R8 irq", {31'b0, irq_eom}, 1);
  endtask

  task automatic t_halt;
    logic [31:0] d;
    int seen;
    wr(3'd4, 32'h00);
    rd(3'd4, d); check("R10 de cleared, flags kept", d, 32'h40);
    seen = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h33; in_last = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (in_ready || mem_req) seen++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    check("R11 quiet while halted", seen, 0);
    rd(3'd0, d); check("R11 cur kept", d, 32'h00);
  endtask

  task automatic t_single_mode;
    logic [31:0] d;
    wr(3'd3, 32'h00); wr(3'd4, 32'h02);
    send(1, 8'h99, 5'b0);
    check("R13 writeback", mem[2], 32'h0080_0001);
    check("R13 byte", {24'b0, mbyte(32'h200)}, 32'h99);
    rd(3'd4, d); check("R13 de dropped", d, 32'hC0);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    wr(3'd5, 32'h1);
    rd(3'd4, d); check("R12 csr cleared", d, 0);
    check("R12 irq cleared", {31'b0, irq_eom}, 0);
  endtask

  task automatic t_saturate;
    logic [31:0] d;
    wr(3'd1, 32'h3F0); wr(3'd3, 32'h14); wr(3'd4, 32'h02);
    for (int f = 0; f < 3; f++) send(1, 8'(f), 5'b0);
    rd(3'd4, d); check("R9 no cof yet", d, 32'h42);
    check("R9 irq", {31'b0, irq_eom}, 1);
    send(1, 8'hEE, 5'b0);
    rd(3'd4, d); check("R9 cof set", d, 32'h52);
    rd(3'd0, d); check("R9 cur walked", d, 32'h10);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_err = '0;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) begin
      mem[i*4]     = ((i + 1) % 4) * 16;
      mem[i*4 + 1] = 32'h200 + i * 32'h40;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_frame();
    t_long_frame();
    t_drop();
    t_flag_clear();
    t_advance_stop();
    t_halt();
    t_single_mode();
    t_abort();
    t_saturate();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule